// File: doc/BRIEF.md
# Cycle-Stealing Block Transfer Controller

The controller copies a block of words between one peripheral and memory while the CPU keeps running. Software writes four things into it: which way data flows, the peripheral's device number, the first memory address and the number of words. It then sets the start bit and has nothing more to do until the interrupt arrives.

Each word costs exactly one stolen bus cycle. The controller waits until the peripheral says a word can move. It then raises a bus request and waits for the grant. It performs a single memory access while the grant is held, and drops the request in the very next cycle. This hands the bus straight back to the CPU. The CPU sees this as a short pause: no interrupt is taken and no context is saved. The controller sits beside the memory on the shared bus, so each word crosses the bus once. It goes straight between the peripheral port and memory.

When the last word is done, the controller sets a done flag and raises its interrupt. Both stay high until software clears them. A start with a count of zero finishes at once. While a block is running, the register port is locked and every write to it is dropped.

Top module: `cycsteal_dma`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, bus_req, mem_en, mem_we, dev_ack, stat_busy, stat_done and irq are all 0.
- R2: A register write uses cfg_addr as follows: 0 is control, 1 is the device number, 2 is the first memory address and 3 is the word count. The control word has bit 0 for start, bit 1 for direction (1 means peripheral to memory, 0 means memory to peripheral) and bit 2 for clearing done. The direction is taken only from a control write that has start set. dev_sel shows the programmed device number from the cycle after its write.
- R3: bus_req rises only in the cycle after one in which dev_rdy was high and dev_ack was low, while a block is busy. With dev_rdy held low, no request is made.
- R4: mem_en is high only while bus_gnt and bus_req are high. It is high for exactly one cycle per word, and that cycle is the one right after the cycle in which the grant was first sampled during a request.
- R5: In the cycle after the mem_en cycle, bus_req is low and dev_ack pulses high for one cycle.
- R6: With direction 1, memory receives the word that dev_rdata held when the grant was sampled (mem_we=1). With direction 0, mem_we=0, and dev_wdata carries the memory word during the dev_ack cycle.
- R7: After each word, the memory address rises by one, modulo 2^AW, and the remaining count falls by one.
- R8: In the cycle after the last word's mem_en cycle, stat_busy drops and stat_done and irq rise.
- R9: stat_done and irq stay high until a control write with clear or start set. A start with a nonzero count also clears them, and sets stat_busy in the next cycle.
- R10: A start while the count is 0 sets stat_done and irq in the next cycle. It performs no bus cycle and leaves stat_busy low.
- R11: While stat_busy is high, register writes have no effect. This covers the device number, the address, the count, the direction and the start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 2 | Register select |
| cfg_wdata | input | CFG_W | Register write data |
| stat_busy | output | 1 | Block transfer in progress |
| stat_done | output | 1 | Block finished, sticky |
| irq | output | 1 | Completion interrupt, sticky |
| bus_req | output | 1 | Shared bus request |
| bus_gnt | input | 1 | Shared bus grant |
| mem_en | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW | Memory word address |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, valid in the mem_en cycle |
| dev_sel | output | DEVW | Selected peripheral number |
| dev_rdy | input | 1 | Peripheral can move a word |
| dev_rdata | input | DW | Word from the peripheral |
| dev_wdata | output | DW | Word to the peripheral |
| dev_ack | output | 1 | One word taken or delivered |

## Verification
The bench uses the default parameters: AW=12, DW=16, CW=8, DEVW=4 and CFG_W=16. With a 12-bit address, a block that starts at 4094 wraps to address 0 within a few words. With an 8-bit count, a maximum block of 255 words runs in well under the cycle limit. Grant delays of zero to three cycles and a peripheral that drops ready every third cycle show that each word still costs exactly one bus cycle whatever the spacing.

// File: rtl/cycsteal_pkg.sv
package cycsteal_pkg;
  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_WAIT = 2'd1,
    SQ_REQ  = 2'd2,
    SQ_XFER = 2'd3
  } sq_state_t;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_DEV  = 2'd1;
  localparam logic [1:0] OFS_MEM  = 2'd2;
  localparam logic [1:0] OFS_CNT  = 2'd3;

  localparam int CB_START = 0;
  localparam int CB_DIR   = 1;
  localparam int CB_CLEAR = 2;
endpackage

// File: rtl/csd_cfg.sv
module csd_cfg
  import cycsteal_pkg::*;
#(
  parameter int AW    = 12,
  parameter int CW    = 8,
  parameter int DEVW  = 4,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             busy,
  input  logic             step,
  output logic             dir_to_mem,
  output logic [DEVW-1:0]  dev_id,
  output logic [AW-1:0]    cur_addr,
  output logic [CW-1:0]    cur_cnt,
  output logic             last_word,
  output logic             go,
  output logic             instant,
  output logic             clear
);
  logic wr_ok;
  logic ctrl_wr;
  logic unused_wdata;

  assign unused_wdata = ^cfg_wdata;

  always_comb begin
    wr_ok     = cfg_we && !busy;
    ctrl_wr   = wr_ok && (cfg_addr == OFS_CTRL);
    go        = ctrl_wr && cfg_wdata[CB_START] && (cur_cnt != '0);
    instant   = ctrl_wr && cfg_wdata[CB_START] && (cur_cnt == '0);
    clear     = ctrl_wr && cfg_wdata[CB_CLEAR] && !cfg_wdata[CB_START];
    last_word = (cur_cnt == CW'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_to_mem <= 1'b0;
      dev_id     <= '0;
      cur_addr   <= '0;
      cur_cnt    <= '0;
    end else if (wr_ok) begin
      case (cfg_addr)
        OFS_CTRL: if (cfg_wdata[CB_START]) dir_to_mem <= cfg_wdata[CB_DIR];
        OFS_DEV:  dev_id   <= cfg_wdata[DEVW-1:0];
        OFS_MEM:  cur_addr <= cfg_wdata[AW-1:0];
        default:  cur_cnt  <= cfg_wdata[CW-1:0];
      endcase
    end else if (step) begin
      cur_addr <= cur_addr + 1'b1;
      cur_cnt  <= cur_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/csd_seq.sv
module csd_seq
  import cycsteal_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic instant,
  input  logic clear,
  input  logic last_word,
  input  logic dev_rdy,
  input  logic ack_now,
  input  logic bus_gnt,
  output logic busy,
  output logic done,
  output logic irq,
  output logic bus_req,
  output logic load,
  output logic fire
);
  sq_state_t state;

  always_comb begin
    load = (state == SQ_REQ) && bus_gnt;
    fire = (state == SQ_XFER);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= SQ_IDLE;
      busy    <= 1'b0;
      done    <= 1'b0;
      irq     <= 1'b0;
      bus_req <= 1'b0;
    end else begin
      case (state)
        SQ_IDLE: begin
          if (go) begin
            busy  <= 1'b1;
            done  <= 1'b0;
            irq   <= 1'b0;
            state <= SQ_WAIT;
          end else if (instant) begin
            done <= 1'b1;
            irq  <= 1'b1;
          end else if (clear) begin
            done <= 1'b0;
            irq  <= 1'b0;
          end
        end
        SQ_WAIT: begin
          if (dev_rdy && !ack_now) begin
            bus_req <= 1'b1;
            state   <= SQ_REQ;
          end
        end
        SQ_REQ: begin
          if (bus_gnt) state <= SQ_XFER;
        end
        default: begin
          bus_req <= 1'b0;
          if (last_word) begin
            busy  <= 1'b0;
            done  <= 1'b1;
            irq   <= 1'b1;
            state <= SQ_IDLE;
          end else begin
            state <= SQ_WAIT;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/csd_path.sv
module csd_path #(
  parameter int AW = 12,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic          fire,
  input  logic          dir_to_mem,
  input  logic [AW-1:0] cur_addr,
  input  logic [DW-1:0] dev_rdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_ack
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_en    <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      dev_wdata <= '0;
      dev_ack   <= 1'b0;
    end else begin
      mem_en  <= load;
      mem_we  <= load && dir_to_mem;
      dev_ack <= fire;
      if (load) begin
        mem_addr <= cur_addr;
        if (dir_to_mem) mem_wdata <= dev_rdata;
      end
      if (fire && !dir_to_mem) dev_wdata <= mem_rdata;
    end
  end
endmodule

// File: rtl/cycsteal_dma.sv
module cycsteal_dma #(
  parameter int AW    = 12,
  parameter int DW    = 16,
  parameter int CW    = 8,
  parameter int DEVW  = 4,
  parameter int CFG_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_addr,
  input  logic [CFG_W-1:0] cfg_wdata,
  output logic             stat_busy,
  output logic             stat_done,
  output logic             irq,
  output logic             bus_req,
  input  logic             bus_gnt,
  output logic             mem_en,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [DW-1:0]    mem_wdata,
  input  logic [DW-1:0]    mem_rdata,
  output logic [DEVW-1:0]  dev_sel,
  input  logic             dev_rdy,
  input  logic [DW-1:0]    dev_rdata,
  output logic [DW-1:0]    dev_wdata,
  output logic             dev_ack
);
  logic          dir_to_mem;
  logic [AW-1:0] cur_addr;
  logic [CW-1:0] cnt_now;
  logic          last_word;
  logic          go;
  logic          instant;
  logic          clear;
  logic          load;
  logic          fire;

  csd_cfg #(.AW(AW), .CW(CW), .DEVW(DEVW), .CFG_W(CFG_W)) u_cfg (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .busy(stat_busy), .step(fire),
    .dir_to_mem(dir_to_mem), .dev_id(dev_sel), .cur_addr(cur_addr),
    .cur_cnt(cnt_now), .last_word(last_word), .go(go),
    .instant(instant), .clear(clear)
  );

  csd_seq u_seq (
    .clk(clk), .rst(rst), .go(go), .instant(instant), .clear(clear),
    .last_word(last_word), .dev_rdy(dev_rdy), .ack_now(dev_ack),
    .bus_gnt(bus_gnt), .busy(stat_busy), .done(stat_done), .irq(irq),
    .bus_req(bus_req), .load(load), .fire(fire)
  );

  csd_path #(.AW(AW), .DW(DW)) u_path (
    .clk(clk), .rst(rst), .load(load), .fire(fire),
    .dir_to_mem(dir_to_mem), .cur_addr(cur_addr), .dev_rdata(dev_rdata),
    .mem_rdata(mem_rdata), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .dev_wdata(dev_wdata),
    .dev_ack(dev_ack)
  );
endmodule

// File: rtl/cycsteal_dma_chk.sv
module cycsteal_dma_chk #(
  parameter int CW    = 8,
  parameter int CFG_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cfg_we,
  input logic [1:0]       cfg_addr,
  input logic [CFG_W-1:0] cfg_wdata,
  input logic             stat_busy,
  input logic             stat_done,
  input logic             irq,
  input logic             bus_req,
  input logic             bus_gnt,
  input logic             mem_en,
  input logic             dev_rdy,
  input logic             dev_ack,
  input logic [CW-1:0]    cnt_now
);
  // R4
  gnt_held_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |-> (bus_gnt && bus_req && stat_busy));

  // R3
  req_needs_rdy_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req) |-> ($past(dev_rdy) && !$past(dev_ack) && stat_busy));

  // R5
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    mem_en |=> (!mem_en && !bus_req && dev_ack));

  // R9
  sticky_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (irq && !(cfg_we && cfg_addr == 2'd0 && (cfg_wdata[0] || cfg_wdata[2])))
      |=> irq);

  // R10
  zero_start_chk: assert property (@(posedge clk) disable iff (rst)
    (!stat_busy && cfg_we && cfg_addr == 2'd0 && cfg_wdata[0] && cnt_now == '0)
      |=> (stat_done && irq && !stat_busy && !mem_en));

  // R11
  busy_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_busy && !mem_en) |=> $stable(cnt_now));

  // R8
  finish_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(stat_busy) |-> (stat_done && irq && $past(mem_en)));
endmodule

bind cycsteal_dma cycsteal_dma_chk #(.CW(CW), .CFG_W(CFG_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .cfg_wdata(cfg_wdata), .stat_busy(stat_busy), .stat_done(stat_done),
  .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en),
  .dev_rdy(dev_rdy), .dev_ack(dev_ack), .cnt_now(cnt_now)
);

// File: tb/tb_cycsteal_dma.sv
`timescale 1ns/1ps
module tb_cycsteal_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic        stat_busy, stat_done, irq, bus_req, mem_en, mem_we, dev_ack;
  logic        bus_gnt = 1'b0;
  logic        dev_rdy = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata, dev_wdata;
  logic [15:0] dev_rdata = '0;
  logic [3:0]  dev_sel;

  always #2.5 clk = ~clk;

  cycsteal_dma dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .stat_busy(stat_busy), .stat_done(stat_done),
    .irq(irq), .bus_req(bus_req), .bus_gnt(bus_gnt), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .dev_sel(dev_sel), .dev_rdy(dev_rdy),
    .dev_rdata(dev_rdata), .dev_wdata(dev_wdata), .dev_ack(dev_ack)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // bench memory, combinational read
  logic [15:0] mem_arr [0:4095];
  assign mem_rdata = mem_arr[mem_addr];
  always @(posedge clk) if (mem_en && mem_we) mem_arr[mem_addr] <= mem_wdata;

  // peripheral and arbiter environment
  logic [15:0] src_q[$];
  logic [15:0] sink_q[$];
  bit env_dir = 0;
  bit rdy_en = 1;
  bit stall_mode = 0;
  int gnt_lag = 0;
  int lag_cnt = 0;
  int cyc = 0;
  int en_cycles = 0;

  always @(negedge clk) begin
    cyc++;
    if (mem_en) en_cycles++;
    if (dev_ack && !rst) begin
      if (env_dir) begin
        if (src_q.size() > 0) void'(src_q.pop_front());
      end else begin
        sink_q.push_back(dev_wdata);
      end
    end
    dev_rdy = rdy_en && (!stall_mode || (cyc % 3) != 0) &&
              (env_dir ? (src_q.size() > 0) : 1'b1);
    dev_rdata = (src_q.size() > 0) ? src_q[0] : 16'h0;
    if (!bus_req) begin
      bus_gnt = 1'b0;
      lag_cnt = 0;
    end else if (lag_cnt >= gnt_lag) begin
      bus_gnt = 1'b1;
    end else begin
      lag_cnt++;
    end
  end

  // behavioural reference model, advanced on each rising edge
  int ms = 0;
  bit m_req = 0, m_en = 0, m_we = 0, m_ack = 0, m_busy = 0, m_done = 0, m_irq = 0;
  int m_addr_o = 0, m_wd_o = 0, m_dwd = 0, m_cur = 0, m_cnt = 0, m_dev = 0;
  bit m_dir = 0;

  always @(posedge clk) begin : model
    bit wr;
    bit n_en;
    bit n_ack;
    if (rst) begin
      ms = 0; m_req = 0; m_en = 0; m_we = 0; m_ack = 0;
      m_busy = 0; m_done = 0; m_irq = 0; m_addr_o = 0; m_wd_o = 0;
      m_dwd = 0; m_cur = 0; m_cnt = 0; m_dev = 0; m_dir = 0;
    end else begin
      wr = cfg_we && !m_busy;
      n_en = 0;
      n_ack = 0;
      case (ms)
        0: begin
          if (wr && cfg_addr == 2'd0 && cfg_wdata[0]) begin
            if (m_cnt != 0) begin
              m_busy = 1; m_done = 0; m_irq = 0; ms = 1;
            end else begin
              m_done = 1; m_irq = 1;
            end
          end else if (wr && cfg_addr == 2'd0 && cfg_wdata[2]) begin
            m_done = 0; m_irq = 0;
          end
        end
        1: if (dev_rdy && !m_ack) begin m_req = 1; ms = 2; end
        2: if (bus_gnt) begin
          n_en = 1; m_addr_o = m_cur;
          if (m_dir) m_wd_o = int'(dev_rdata);
          ms = 3;
        end
        default: begin
          m_req = 0; n_ack = 1;
          if (!m_dir) m_dwd = int'(mem_arr[m_addr_o]);
          m_cur = (m_cur + 1) % 4096;
          if (m_cnt == 1) begin
            m_busy = 0; m_done = 1; m_irq = 1; ms = 0;
          end else begin
            ms = 1;
          end
          m_cnt = m_cnt - 1;
        end
      endcase
      if (wr) begin
        case (cfg_addr)
          2'd0: if (cfg_wdata[0]) m_dir = cfg_wdata[1];
          2'd1: m_dev = int'(cfg_wdata[3:0]);
          2'd2: m_cur = int'(cfg_wdata[11:0]);
          default: m_cnt = int'(cfg_wdata[7:0]);
        endcase
      end
      m_en = n_en;
      m_we = n_en && m_dir;
      m_ack = n_ack;
    end
  end

  // per-cycle comparison of the outputs against the model
  always @(negedge clk) begin
    if (!rst && !finished) begin
      chk({bus_req, mem_en, mem_we, dev_ack, stat_busy, stat_done, irq} ==
          {m_req, m_en, m_we, m_ack, m_busy, m_done, m_irq},
          "R4 R5 R8", "per-cycle control {req,en,we,ack,busy,done,irq}",
          int'({bus_req, mem_en, mem_we, dev_ack, stat_busy, stat_done, irq}),
          int'({m_req, m_en, m_we, m_ack, m_busy, m_done, m_irq}));
      chk(int'(dev_sel) == m_dev, "R2", "per-cycle dev_sel", int'(dev_sel), m_dev);
      if (mem_en) begin
        chk(int'(mem_addr) == m_addr_o, "R7", "per-cycle mem_addr",
            int'(mem_addr), m_addr_o);
        if (m_we)
          chk(int'(mem_wdata) == m_wd_o, "R6", "per-cycle mem_wdata",
              int'(mem_wdata), m_wd_o);
      end
      if (dev_ack && !m_dir)
        chk(int'(dev_wdata) == m_dwd, "R6", "per-cycle dev_wdata",
            int'(dev_wdata), m_dwd);
    end
  end

  task automatic cfg_write(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic run_block(input bit dir, input int dev, input int base, input int cnt);
    cfg_write(2'd1, 16'(dev));
    cfg_write(2'd2, 16'(base));
    cfg_write(2'd3, 16'(cnt));
    env_dir = dir;
    cfg_write(2'd0, 16'(1 | (int'(dir) << 1)));
  endtask

  task automatic wait_done(input string tag);
    int n = 0;
    while (!stat_done && n < 20000) begin
      @(negedge clk);
      n++;
    end
    chk(stat_done && irq && !stat_busy, tag, "completion {done,irq,busy}",
        int'({stat_done, irq, stat_busy}), 6);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem_arr[i] = 16'h0;
  end

  initial begin : stim
    int e0;
    repeat (4) @(negedge clk);
    chk({bus_req, mem_en, stat_busy, stat_done, irq, dev_ack} == 6'b0, "R1",
        "outputs in reset", int'({bus_req, mem_en, stat_busy, stat_done, irq, dev_ack}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk({bus_req, mem_en, mem_we, stat_busy, stat_done, irq, dev_ack} == 7'b0, "R1",
        "outputs after reset", int'({bus_req, mem_en, stat_busy, stat_done, irq, dev_ack}), 0);

    // zero count start
    cfg_write(2'd3, 16'd0);
    e0 = en_cycles;
    cfg_write(2'd0, 16'h1);
    chk(stat_done && irq && !stat_busy, "R10", "zero count done at once",
        int'({stat_done, irq, stat_busy}), 6);
    repeat (5) @(negedge clk);
    chk(en_cycles == e0, "R10", "zero count bus cycles", en_cycles - e0, 0);
    chk(irq && stat_done, "R9", "irq sticky while idle", int'({irq, stat_done}), 3);
    cfg_write(2'd0, 16'h4);
    chk(!irq && !stat_done, "R9", "clear write", int'({irq, stat_done}), 0);

    // peripheral to memory, immediate grant
    for (int i = 0; i < 6; i++) src_q.push_back(16'hA000 + 16'(i));
    gnt_lag = 0;
    e0 = en_cycles;
    run_block(1'b1, 5, 16, 6);
    chk(dev_sel == 4'd5, "R2", "dev_sel programmed", int'(dev_sel), 5);
    wait_done("R8");
    for (int i = 0; i < 6; i++)
      chk(mem_arr[16 + i] == 16'hA000 + 16'(i), "R6", "memory word from device",
          int'(mem_arr[16 + i]), 'hA000 + i);
    chk(en_cycles - e0 == 6, "R4", "one bus cycle per word", en_cycles - e0, 6);

    // memory to peripheral, late grant, stalling peripheral
    for (int i = 0; i < 5; i++) mem_arr[256 + i] = 16'h5100 + 16'(i * 3);
    sink_q.delete();
    gnt_lag = 3;
    rdy_en = 0;
    run_block(1'b0, 2, 256, 5);
    chk(!stat_done && !irq && stat_busy, "R9", "start clears done",
        int'({stat_done, irq, stat_busy}), 1);
    repeat (10) @(negedge clk);
    chk(!bus_req, "R3", "no request without ready", int'(bus_req), 0);
    stall_mode = 1;
    rdy_en = 1;
    wait_done("R8");
    @(negedge clk);
    chk(sink_q.size() == 5, "R6", "words delivered", sink_q.size(), 5);
    for (int i = 0; i < 5; i++)
      if (i < sink_q.size())
        chk(sink_q[i] == 16'h5100 + 16'(i * 3), "R6", "device word from memory",
            int'(sink_q[i]), 'h5100 + i * 3);

    // address wrap at the top of memory
    stall_mode = 0;
    gnt_lag = 1;
    for (int i = 0; i < 4; i++) src_q.push_back(16'hC0DE + 16'(i));
    run_block(1'b1, 7, 4094, 4);
    wait_done("R8");
    chk(mem_arr[4094] == 16'hC0DE, "R7", "word at 4094", int'(mem_arr[4094]), 'hC0DE);
    chk(mem_arr[4095] == 16'hC0DF, "R7", "word at 4095", int'(mem_arr[4095]), 'hC0DF);
    chk(mem_arr[0] == 16'hC0E0, "R7", "wrapped word at 0", int'(mem_arr[0]), 'hC0E0);
    chk(mem_arr[1] == 16'hC0E1, "R7", "wrapped word at 1", int'(mem_arr[1]), 'hC0E1);

    // writes while busy are dropped
    for (int i = 0; i < 4; i++) src_q.push_back(16'h7700 + 16'(i));
    e0 = en_cycles;
    run_block(1'b1, 3, 512, 4);
    cfg_write(2'd1, 16'd9);
    cfg_write(2'd2, 16'd768);
    cfg_write(2'd3, 16'd50);
    cfg_write(2'd0, 16'h1);
    chk(dev_sel == 4'd3, "R11", "dev_sel kept while busy", int'(dev_sel), 3);
    wait_done("R11");
    chk(en_cycles - e0 == 4, "R11", "count kept while busy", en_cycles - e0, 4);
    chk(mem_arr[515] == 16'h7703, "R11", "address kept while busy",
        int'(mem_arr[515]), 'h7703);
    chk(mem_arr[768] == 16'h0, "R11", "ignored address untouched",
        int'(mem_arr[768]), 0);

    // largest block, memory to peripheral
    for (int i = 0; i < 255; i++) mem_arr[1024 + i] = 16'(i) ^ 16'h3C3C;
    sink_q.delete();
    gnt_lag = 0;
    e0 = en_cycles;
    run_block(1'b0, 1, 1024, 255);
    wait_done("R8");
    @(negedge clk);
    chk(en_cycles - e0 == 255, "R4", "bus cycles for 255 words", en_cycles - e0, 255);
    chk(sink_q.size() == 255, "R7", "255 words delivered", sink_q.size(), 255);
    for (int i = 0; i < 255; i++)
      if (i < sink_q.size())
        chk(sink_q[i] == (16'(i) ^ 16'h3C3C), "R7", "long block word",
            int'(sink_q[i]), i ^ 'h3C3C);

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL R8 watchdog: actual=hung expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule